// File: doc/BRIEF.md
# Double-Buffered 16-bit Compare Timer

This block is a 16-bit up counter with two 16-bit compare registers. Each register raises a one-cycle match strobe when the counter equals its value. Software loads each compare register with two byte writes over an 8-bit write bus. The low byte is held in a staging register, and the full 16-bit value takes effect when the high byte is written.

The first compare register (slot 0) has a shadow buffer that shares its two addresses. A control byte holds a run bit and a double-buffer enable bit. When double buffering is off, writes to slot 0 land in both slot 0 and the buffer. When it is on, writes land only in the buffer. The buffer is moved into slot 0 when the counter matches slot 1. Software can therefore retarget slot 0 in step with the period that slot 1 defines, without a glitch.

The compare registers are write-only, and the block has no read path. Their reset contents are not part of the contract, so software must load them before it sets the run bit.

Top module: `dbuf_cmp_timer`

## Requirements
- R1: After reset, `count_o` is 0, both match strobes are low, and the control byte is 0, so the timer is stopped and double buffering is off.
- R2: On a cycle with `tick_i` high and the run bit (control bit 0) set, the counter adds one, wrapping from 0xFFFF to 0x0000. On any other cycle it holds its value.
- R3: A compare value is loaded by writing its low byte to the even address (0x188 for slot 0, 0x18A for slot 1) and then its high byte to the next odd address (0x189, 0x18B). A low-byte write alone leaves the effective compare value unchanged.
- R4: A write to 0x180 sets the control byte. Bit 0 is run and bit 1 is double-buffer enable. The new setting first applies on the following cycle.
- R5: `match0_o` or `match1_o` is high for exactly one cycle: the cycle after a counting cycle (R2) on which the counter value before its increment equals that slot's compare value. At no other time is it high.
- R6: With double buffering off, a high-byte write to slot 0 updates both slot 0 and its buffer.
- R7: With double buffering on, a high-byte write to slot 0 updates only the buffer, and slot 0 keeps comparing against its old value.
- R8: With double buffering on, a counting cycle on which the counter equals slot 1 copies the buffer into slot 0. The slot 0 comparison on that same cycle still uses the old slot 0 value, and the new value applies from the next counting cycle.
- R9: A write to any address other than 0x180 and 0x188 through 0x18B has no effect on the counter, the compare values or the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 24 | Byte write address |
| wr_data_i | input | 8 | Byte write data |
| tick_i | input | 1 | Count tick, one increment per high cycle while running |
| count_o | output | 16 | Current counter value |
| match0_o | output | 1 | Slot 0 match strobe |
| match1_o | output | 1 | Slot 1 match strobe |

## Verification
Both compare slots are exercised first with double buffering off. That run uses continuous ticks, ticks with gaps and a paused run bit. It separates a counter that steps on the wrong condition from one that steps only on counting cycles, and it shows whether a stray low-byte write or an unmapped write leaks into a compare value. With double buffering on, a buffer-only write is followed by a slot 1 match at a different count. This tells apart a design that writes slot 0 directly from one that defers the update until the copy. A second pass sets slot 0 and slot 1 to the same value, so that the slot 0 comparison and the buffer copy fall on the same tick. A final run of 65,536 continuous ticks covers the wrap and the second match of each slot on the next lap.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NCMP   = 2;

  // control byte fields, bit 0 = run, bit 1 = double-buffer enable
  typedef struct packed {
    logic dben;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/dbt_regif.sv
module dbt_regif #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = dbt_pkg::BYTE_W,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 24'h000180,
  parameter logic [ADDR_W-1:0] RG0_ADDR  = 24'h000188,
  parameter logic [ADDR_W-1:0] RG1_ADDR  = 24'h00018A,
  localparam int unsigned CW = 2 * DATA_W,
  localparam int unsigned NR = dbt_pkg::NCMP
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  output dbt_pkg::ctrl_t            ctrl_o,
  output logic [NR-1:0]             commit_o,
  output logic [NR-1:0][CW-1:0]     value_o
);
  dbt_pkg::ctrl_t ctrl_q;
  logic ctrl_hit;

  assign ctrl_hit = wr_en_i && (wr_addr_i == CTRL_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (ctrl_hit) ctrl_q <= dbt_pkg::ctrl_t'(wr_data_i[1:0]);
  end
  assign ctrl_o = ctrl_q;

  for (genvar i = 0; i < NR; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] BASE = (i == 0) ? RG0_ADDR : RG1_ADDR;
    logic [DATA_W-1:0] stage_q;
    logic lo_hit, hi_hit;

    assign lo_hit = wr_en_i && (wr_addr_i == BASE);
    assign hi_hit = wr_en_i && (wr_addr_i == BASE + ADDR_W'(1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q <= '0;
      else if (lo_hit) stage_q <= wr_data_i;
    end

    // value commits only with the high byte
    assign commit_o[i] = hi_hit;
    assign value_o[i]  = {wr_data_i, stage_q};
  end
endmodule

// File: rtl/dbt_rg0_bank.sv
module dbt_rg0_bank #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          commit_i,
  input  logic [CW-1:0] value_i,
  input  logic          dben_i,
  input  logic          copy_i,
  output logic [CW-1:0] rg_o,
  output logic [CW-1:0] buf_o
);
  logic [CW-1:0] rg_q, buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rg_q  <= '0;
      buf_q <= '0;
    end else begin
      if (commit_i) buf_q <= value_i;
      // direct write and copy cannot coincide: they need opposite dben
      if (commit_i && !dben_i) rg_q <= value_i;
      else if (copy_i && dben_i) rg_q <= buf_q;
    end
  end

  assign rg_o  = rg_q;
  assign buf_o = buf_q;
endmodule

// File: rtl/dbt_counter.sv
module dbt_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dbt_cmp.sv
module dbt_cmp #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] ref_i,
  output logic          hit_o,
  output logic          strobe_o
);
  logic strobe_q;

  assign hit_o = step_i && (cnt_i == ref_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else strobe_q <= hit_o;
  end

  assign strobe_o = strobe_q;
endmodule

// File: rtl/dbuf_cmp_timer.sv
module dbuf_cmp_timer #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = dbt_pkg::BYTE_W,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 24'h000180,
  parameter logic [ADDR_W-1:0] RG0_ADDR  = 24'h000188,
  parameter logic [ADDR_W-1:0] RG1_ADDR  = 24'h00018A,
  localparam int unsigned CW = 2 * DATA_W,
  localparam int unsigned NR = dbt_pkg::NCMP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tick_i,
  output logic [CW-1:0]     count_o,
  output logic              match0_o,
  output logic              match1_o
);
  dbt_pkg::ctrl_t          ctrl;
  logic [NR-1:0]           commit;
  logic [NR-1:0][CW-1:0]   value;
  logic [CW-1:0]           cnt_q, rg0_q, rg1_q, buf_q;
  logic [CW-1:0]           ref_v [NR];
  logic [NR-1:0]           hit, strobe;
  logic                    step, copy;

  dbt_regif #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CTRL_ADDR(CTRL_ADDR), .RG0_ADDR(RG0_ADDR), .RG1_ADDR(RG1_ADDR)
  ) u_regif (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ctrl_o(ctrl), .commit_o(commit), .value_o(value)
  );

  assign step = tick_i && ctrl.run;
  assign copy = hit[1] && ctrl.dben;

  dbt_counter #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .step_i(step), .cnt_o(cnt_q)
  );

  dbt_rg0_bank #(.CW(CW)) u_rg0 (
    .clk_i, .rst_ni,
    .commit_i(commit[0]), .value_i(value[0]),
    .dben_i(ctrl.dben), .copy_i(copy),
    .rg_o(rg0_q), .buf_o(buf_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rg1_q <= '0;
    else if (commit[1]) rg1_q <= value[1];
  end

  assign ref_v[0] = rg0_q;
  assign ref_v[1] = rg1_q;

  for (genvar i = 0; i < NR; i++) begin : g_cmp
    dbt_cmp #(.CW(CW)) u_cmp (
      .clk_i, .rst_ni, .step_i(step), .cnt_i(cnt_q), .ref_i(ref_v[i]),
      .hit_o(hit[i]), .strobe_o(strobe[i])
    );
  end

  assign count_o  = cnt_q;
  assign match0_o = strobe[0];
  assign match1_o = strobe[1];
endmodule

// File: rtl/dbt_checker.sv
module dbt_checker #(
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          run,
  input logic          dben,
  input logic          commit0,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] rg0,
  input logic [CW-1:0] rg1,
  input logic [CW-1:0] bufv,
  input logic          match0_o,
  input logic          match1_o
);
  logic step_c;
  assign step_c = tick_i && run;

  a_r1_reset_state: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (cnt == '0) && !run && !dben && !match0_o && !match1_o);

  a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_c |=> cnt == $past(cnt) + CW'(1));

  a_r2_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_c |=> $stable(cnt));

  a_r5_match0_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_c && cnt == rg0) |=> match0_o);

  a_r5_match1_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_c && cnt == rg1) |=> match1_o);

  a_r5_match0_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_c && cnt == rg0) |=> !match0_o);

  a_r5_match1_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_c && cnt == rg1) |=> !match1_o);

  a_r6_write_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit0 && !dben) |=> rg0 == bufv);

  a_r7_buffer_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit0 && dben && !(step_c && cnt == rg1)) |=> $stable(rg0));

  a_r8_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dben && step_c && cnt == rg1) |=> rg0 == $past(bufv));
endmodule

bind dbuf_cmp_timer dbt_checker #(.CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
  .run(ctrl.run), .dben(ctrl.dben), .commit0(commit[0]),
  .cnt(cnt_q), .rg0(rg0_q), .rg1(rg1_q), .bufv(buf_q),
  .match0_o(match0_o), .match1_o(match1_o)
);

// File: tb/tb_dbuf_cmp_timer.sv
`timescale 1ns/1ps
module tb_dbuf_cmp_timer;
  localparam logic [23:0] A_CTRL = 24'h000180;
  localparam logic [23:0] A_RG0L = 24'h000188;
  localparam logic [23:0] A_RG0H = 24'h000189;
  localparam logic [23:0] A_RG1L = 24'h00018A;
  localparam logic [23:0] A_RG1H = 24'h00018B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [23:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        tick = 1'b0;
  logic [15:0] count;
  logic        m0, m1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference model state
  int  r_cnt = 0, r_rg0 = 0, r_rg1 = 0, r_buf = 0, r_lo0 = 0, r_lo1 = 0;
  bit  r_run = 0, r_dben = 0, r_m0 = 0, r_m1 = 0;

  always #2 clk = ~clk;

  dbuf_cmp_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .tick_i(tick), .count_o(count),
    .match0_o(m0), .match1_o(m1)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_cnt = 0; r_run = 0; r_dben = 0; r_m0 = 0; r_m1 = 0;
      r_rg0 = 0; r_rg1 = 0; r_buf = 0; r_lo0 = 0; r_lo1 = 0;
    end else begin
      bit step, cp, direct;
      int old_buf;
      step    = tick && r_run;
      cp      = step && r_dben && (r_cnt == r_rg1);
      old_buf = r_buf;
      direct  = 0;
      r_m0 = step && (r_cnt == r_rg0);
      r_m1 = step && (r_cnt == r_rg1);
      if (step) r_cnt = (r_cnt + 1) % 65536;
      if (wr_en) begin
        if (wr_addr == A_RG0H) begin
          r_buf = wr_data * 256 + r_lo0;
          if (!r_dben) begin r_rg0 = r_buf; direct = 1; end
        end else if (wr_addr == A_RG1H) r_rg1 = wr_data * 256 + r_lo1;
        else if (wr_addr == A_RG0L) r_lo0 = wr_data;
        else if (wr_addr == A_RG1L) r_lo1 = wr_data;
        else if (wr_addr == A_CTRL) begin r_run = wr_data[0]; r_dben = wr_data[1]; end
      end
      if (cp && !direct) r_rg0 = old_buf;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    chk({"R2 count ", tag}, int'(count), r_cnt);
    chk({"R5 match0 ", tag}, int'(m0), int'(r_m0));
    chk({"R5 match1 ", tag}, int'(m1), int'(r_m1));
  end

  task automatic wr(input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic wr16(input logic [23:0] lo, input logic [15:0] v);
    wr(lo, v[7:0]);
    wr(lo + 24'd1, v[15:8]);
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 count", int'(count), 0);
    chk("R1 match0", int'(m0), 0);
    chk("R1 match1", int'(m1), 0);
    rst_n = 1'b1;
    // R1/R4: stopped after reset, ticks ignored
    ticks(4, 0);
    chk("R1 stopped count", int'(count), 0);

    tag = "R3";
    wr16(A_RG1L, 16'h0010);
    wr16(A_RG0L, 16'h0005);
    wr(A_RG0L, 8'h07);            // low byte alone: no effect (R3)
    tag = "R4";
    wr(A_CTRL, 8'h01);
    tag = "R3";
    ticks(24, 0);
    chk("R3 count after 24 ticks", int'(count), 24);

    tag = "R9";
    wr(24'h00018C, 8'hFF);
    wr(24'h00018D, 8'hFF);
    wr(24'h000181, 8'h00);
    ticks(10, 1);
    tag = "R2";
    wr(A_CTRL, 8'h00);
    ticks(5, 0);
    chk("R2 paused count", int'(count), 34);
    wr(A_CTRL, 8'h01);

    tag = "R6";
    wr16(A_RG0L, 16'h0030);
    ticks(14, 0);                 // match0 at 0x30 via direct write
    tag = "R7";
    wr(A_CTRL, 8'h03);
    wr16(A_RG0L, 16'h0050);       // buffer only
    wr16(A_RG1L, 16'h0040);
    ticks(40, 0);                 // counts 0x30..0x57
    tag = "R8";
    ticks(4, 0);

    // same-tick case: slot 0 and slot 1 both at 0x70
    wr(A_CTRL, 8'h01);
    wr16(A_RG0L, 16'h0070);
    wr(A_CTRL, 8'h03);
    wr16(A_RG0L, 16'h0090);
    wr16(A_RG1L, 16'h0070);
    ticks(70, 0);
    chk("R8 count", int'(count), 16'h00A2);

    tag = "R2 wrap";
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
    chk("R2 wrap count", int'(count), 16'h00A2);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule